// File: doc/BRIEF.md
# ADC Sample Request and Status Tracker

This block sits between software and an ADC conversion engine and keeps track of a bank of sample slots (parameter `N`, default 19). Software fires a software trigger with a slot mask, and each selected slot becomes pending. A fixed-priority arbiter hands the lowest-numbered pending slot to the converter through a start/done handshake. When the converter returns a 16-bit result, the result is latched into that slot's result word, the slot's valid flag is set, and its pending bit drops.

Two kinds of overrun are tracked. An event overrun is a trigger that hits a slot which is already pending. A data overrun is a result that lands on a word that has not been read. Four interrupt lines each select a subset of slots. Each slot is flagged either when its conversion starts or when it ends. Start-flagged events can be delayed per line by 0 to 15 cycles. A flag that is raised again while it is still set marks an overwrite on its line. All state is reached through a single-cycle register write port and a combinational read port.

Top module: `adc_slot_tracker`

## Requirements
- R1: Writing a mask to address 0x00 sets the pending bit of each selected slot. Pending bits read at address 0x01, bit n for slot n. A slot's pending bit clears when its conversion completes.
- R2: While no conversion is in flight and at least one slot is pending, `conv_start` is high for exactly one cycle and `conv_slot` names the lowest-numbered pending slot. `busy` (also status bit 8) is 1 from the cycle after that start until the cycle after the accepted `conv_done`.
- R3: Writing 1s to address 0x01 cancels those slots' pending requests. A cancelled slot that has not been issued is never issued.
- R4: A trigger that selects a slot that is already pending sets that slot's event-overrun bit (address 0x02, bit n) and adds no second conversion. Writing 1s to 0x02 clears those bits.
- R5: The result word of slot n is at address 0x20+n. Bits 15:0 hold the result, bit 16 is data overrun and bit 17 is valid. A completed conversion sets valid. It sets overrun if valid was still 1. A read with `rd_en` high clears both flags.
- R6: Status word 0x03 carries summary bits: bit 9 is any valid, bit 10 is any data overrun, bit 11 is any event overrun and bit 12 is any line overwrite.
- R7: Line k is fed only by the slots selected in its mask at address 0x08+k. Its flag is status bit k, and `irq[k]` equals that flag ANDed with enable bit k of address 0x04. Writing 1 to status bit k clears the flag.
- R8: The mode register at address 0x05 chooses, per slot, whether that slot flags at the start of its conversion (bit = 1) or at the end (bit = 0). An end flag is set at the clock edge that accepts `conv_done`.
- R9: A start flag on line k is set d clock edges after the edge that accepts `conv_start`. Here d is bits 4k+3:4k of address 0x06. A delay of 0 sets the flag at the accepting edge itself.
- R10: An event that sets line k's flag while the flag is already 1 sets overwrite bit 4+k of the status word. Writing 1 to that bit clears it.
- R11: After reset every register, flag, pending bit and result word reads 0, and `conv_start`, `busy` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; clears result flags when it hits a result word |
| rd_addr | input | 6 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| conv_start | output | 1 | Request to start a conversion |
| conv_slot | output | 5 | Slot being started |
| conv_done | input | 1 | Converter finished; accepted only while busy |
| conv_result | input | 16 | Result that accompanies `conv_done` |
| busy | output | 1 | Conversion in flight |
| irq | output | 4 | Enabled interrupt lines |

## Verification
The hardest case is an event that arrives while a slot is still in flight, such as a retrigger or a cancel. Ports alone cannot hold a conversion open. So the bench plays the converter itself and withholds `conv_done` while it writes triggers and cancels. It then releases the conversion and checks which slots are issued next and that no slot is issued twice. The start-of-conversion delay is swept across all sixteen values. For each value the bench holds the conversion open and counts clock edges from the accepted start until `irq` rises.

// File: rtl/adc_trk_pkg.sv
`timescale 1ns/1ps
// Shared constants for the ADC slot tracker: register address map and
// bus widths. Assumes at most 32 slots so every slot mask fits one bus word.
package adc_trk_pkg;
    localparam int ADDR_W = 6;
    localparam int BUS_W  = 32;
    localparam int RES_W  = 16;

    localparam logic [ADDR_W-1:0] A_TRIG = 6'h00;
    localparam logic [ADDR_W-1:0] A_PEND = 6'h01;
    localparam logic [ADDR_W-1:0] A_EVOV = 6'h02;
    localparam logic [ADDR_W-1:0] A_STAT = 6'h03;
    localparam logic [ADDR_W-1:0] A_IEN  = 6'h04;
    localparam logic [ADDR_W-1:0] A_MODE = 6'h05;
    localparam logic [ADDR_W-1:0] A_DLY  = 6'h06;
    localparam logic [ADDR_W-1:0] A_LSEL = 6'h08;
    localparam logic [ADDR_W-1:0] A_RES  = 6'h20;
endpackage

// File: rtl/adc_trk_queue.sv
`timescale 1ns/1ps
// Request queue: holds one pending bit per slot, detects retriggers of a
// pending slot, and issues the lowest pending slot to the converter.
// Assumes the trigger, cancel and clear writes are mutually exclusive
// (they come from one write port).
module adc_trk_queue #(
    parameter int N  = 19,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_we,
    input  logic          cancel_we,
    input  logic          evov_clr_we,
    input  logic [N-1:0]  wmask,
    input  logic          conv_done,
    output logic [N-1:0]  pending_q,
    output logic [N-1:0]  evov_q,
    output logic          busy_q,
    output logic [SW-1:0] cur_q,
    output logic          conv_start,
    output logic [SW-1:0] start_slot,
    output logic          done_acc
);
    logic [N-1:0] done_mask;
    logic [N-1:0] collide;
    logic [N-1:0] pending_d;
    logic [N-1:0] evov_d;

    // Fixed-priority pick of the lowest pending slot.
    always_comb begin
        start_slot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending_q[i]) start_slot = SW'(i);
        end
        conv_start = !busy_q && (|pending_q);
    end

    // Next pending and event-overrun state.
    always_comb begin
        done_acc  = busy_q && conv_done;
        done_mask = done_acc ? (N'(1) << cur_q) : '0;
        collide   = trig_we ? (wmask & pending_q & ~done_mask) : '0;
        pending_d = (pending_q & ~(cancel_we ? wmask : '0) & ~done_mask)
                  | (trig_we ? wmask : '0);
        evov_d    = (evov_q & ~(evov_clr_we ? wmask : '0)) | collide;
    end

    // Pending and event-overrun registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            evov_q    <= '0;
        end else begin
            pending_q <= pending_d;
            evov_q    <= evov_d;
        end
    end

    // Conversion-in-flight tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cur_q  <= '0;
        end else if (conv_start) begin
            busy_q <= 1'b1;
            cur_q  <= start_slot;
        end else if (done_acc) begin
            busy_q <= 1'b0;
        end
    end

    // R2
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (!busy_q && pending_q[start_slot]));

    // R2
    start_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ((pending_q & ((N'(1) << start_slot) - N'(1))) == '0));

    // R2
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && conv_done) |=> !busy_q);

    // R4
    evov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evov_clr_we |=> (($past(evov_q) & ~evov_q) == '0));
endmodule

// File: rtl/adc_trk_results.sv
`timescale 1ns/1ps
// Result store: one data word with valid and data-overrun flags per slot.
// A completed conversion writes the current slot; a read strobe clears the
// addressed slot's flags. A completion takes priority over a same-cycle read.
module adc_trk_results #(
    parameter int N     = 19,
    parameter int SW    = 5,
    parameter int RES_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done_acc,
    input  logic [SW-1:0]      cur_slot,
    input  logic [RES_W-1:0]   result,
    input  logic               rd_clr,
    input  logic [SW-1:0]      rd_slot,
    output logic [N*RES_W-1:0] data_flat,
    output logic [N-1:0]       valid_q,
    output logic [N-1:0]       ovr_q
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        logic hit_done;
        logic hit_rd;
        assign hit_done = done_acc && (cur_slot == SW'(i));
        assign hit_rd   = rd_clr && (rd_slot == SW'(i));

        // Capture a result or clear the flags on a read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_flat[i*RES_W +: RES_W] <= '0;
                valid_q[i] <= 1'b0;
                ovr_q[i]   <= 1'b0;
            end else if (hit_done) begin
                data_flat[i*RES_W +: RES_W] <= result;
                valid_q[i] <= 1'b1;
                ovr_q[i]   <= valid_q[i] && !hit_rd;
            end else if (hit_rd) begin
                valid_q[i] <= 1'b0;
                ovr_q[i]   <= 1'b0;
            end
        end
    end

    // R5
    ovr_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q & ~valid_q) == '0);

    // R5
    done_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_acc |=> valid_q[$past(cur_slot)]);
endmodule

// File: rtl/adc_trk_irq_line.sv
`timescale 1ns/1ps
// One interrupt line: collects start or end events from its selected slots,
// delays start events through a tapped shift line, and keeps a flag plus an
// overwrite flag. Assumes the delay field is DW bits wide (0 .. 2**DW-1).
module adc_trk_irq_line #(
    parameter int N  = 19,
    parameter int SW = 5,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  sel_mask,
    input  logic [N-1:0]  start_mode,
    input  logic          start_ev,
    input  logic [SW-1:0] start_slot,
    input  logic          done_ev,
    input  logic [SW-1:0] done_slot,
    input  logic [DW-1:0] delay,
    input  logic          clr_flag,
    input  logic          clr_ovw,
    output logic          flag_q,
    output logic          ovw_q
);
    localparam int DEPTH = (1 << DW) - 1;

    logic             soc_hit;
    logic             eoc_hit;
    logic             fire;
    logic [DEPTH-1:0] pipe_q;
    logic [DEPTH:0]   tap;

    // Event qualification and delay tap selection.
    always_comb begin
        soc_hit = start_ev && sel_mask[start_slot] && start_mode[start_slot];
        eoc_hit = done_ev && sel_mask[done_slot] && !start_mode[done_slot];
        tap     = {pipe_q, soc_hit};
        fire    = tap[delay] || eoc_hit;
    end

    // Shift line carrying start events toward their delayed tap.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= tap[DEPTH-1:0];
    end

    // Flag and overwrite registers; a new event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ovw_q  <= 1'b0;
        end else begin
            if (fire)          flag_q <= 1'b1;
            else if (clr_flag) flag_q <= 1'b0;
            if (fire && flag_q) ovw_q <= 1'b1;
            else if (clr_ovw)   ovw_q <= 1'b0;
        end
    end

    // R10
    ovw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && flag_q) |=> ovw_q);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_flag) |=> flag_q);
endmodule

// File: rtl/adc_slot_tracker.sv
`timescale 1ns/1ps
// Top of the ADC slot tracker: register decode, read mux, and wiring of the
// request queue, result store and interrupt lines. Assumes N <= 32 and
// LINES*DW <= 32 so every control field fits one bus word.
module adc_slot_tracker
    import adc_trk_pkg::*;
#(
    parameter int N     = 19,
    parameter int LINES = 4,
    parameter int DW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BUS_W-1:0]     wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BUS_W-1:0]     rd_data,
    output logic                 conv_start,
    output logic [$clog2(N)-1:0] conv_slot,
    input  logic                 conv_done,
    input  logic [RES_W-1:0]     conv_result,
    output logic                 busy,
    output logic [LINES-1:0]     irq
);
    localparam int SW = $clog2(N);

    logic [N-1:0]        pending;
    logic [N-1:0]        evov;
    logic [SW-1:0]       cur_slot;
    logic                done_acc;
    logic [N*RES_W-1:0]  data_flat;
    logic [N-1:0]        valid;
    logic [N-1:0]        ovr;
    logic [LINES-1:0]    ien_q;
    logic [N-1:0]        mode_q;
    logic [LINES*DW-1:0] dly_q;
    logic [N-1:0]        lsel_q [LINES];
    logic [LINES-1:0]    flag;
    logic [LINES-1:0]    ovw;
    logic                stat_we;
    logic                res_hit;
    logic [SW-1:0]       rd_slot;
    logic [ADDR_W-1:0]   rd_off;

    // Control register writes: enables, slot modes, line delays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            mode_q <= '0;
            dly_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_IEN)  ien_q  <= wr_data[LINES-1:0];
            if (wr_addr == A_MODE) mode_q <= wr_data[N-1:0];
            if (wr_addr == A_DLY)  dly_q  <= wr_data[LINES*DW-1:0];
        end
    end

    for (genvar k = 0; k < LINES; k++) begin : g_lsel
        // Slot-select mask of line k.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lsel_q[k] <= '0;
            else if (wr_en && wr_addr == A_LSEL + ADDR_W'(k))
                lsel_q[k] <= wr_data[N-1:0];
        end
    end

    assign stat_we = wr_en && (wr_addr == A_STAT);

    adc_trk_queue #(.N(N), .SW(SW)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_we     (wr_en && wr_addr == A_TRIG),
        .cancel_we   (wr_en && wr_addr == A_PEND),
        .evov_clr_we (wr_en && wr_addr == A_EVOV),
        .wmask       (wr_data[N-1:0]),
        .conv_done   (conv_done),
        .pending_q   (pending),
        .evov_q      (evov),
        .busy_q      (busy),
        .cur_q       (cur_slot),
        .conv_start  (conv_start),
        .start_slot  (conv_slot),
        .done_acc    (done_acc)
    );

    // Decode of the result-word window on the read port.
    always_comb begin
        rd_off  = rd_addr - A_RES;
        res_hit = (rd_addr >= A_RES) && (rd_off < ADDR_W'(N));
        rd_slot = rd_off[SW-1:0];
    end

    adc_trk_results #(.N(N), .SW(SW), .RES_W(RES_W)) u_results (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_acc  (done_acc),
        .cur_slot  (cur_slot),
        .result    (conv_result),
        .rd_clr    (rd_en && res_hit),
        .rd_slot   (rd_slot),
        .data_flat (data_flat),
        .valid_q   (valid),
        .ovr_q     (ovr)
    );

    for (genvar k = 0; k < LINES; k++) begin : g_line
        adc_trk_irq_line #(.N(N), .SW(SW), .DW(DW)) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_mask   (lsel_q[k]),
            .start_mode (mode_q),
            .start_ev   (conv_start),
            .start_slot (conv_slot),
            .done_ev    (done_acc),
            .done_slot  (cur_slot),
            .delay      (dly_q[k*DW +: DW]),
            .clr_flag   (stat_we && wr_data[k]),
            .clr_ovw    (stat_we && wr_data[LINES+k]),
            .flag_q     (flag[k]),
            .ovw_q      (ovw[k])
        );
    end

    assign irq = flag & ien_q;

    // Read multiplexer over all registers and result words.
    always_comb begin
        rd_data = '0;
        if (res_hit) begin
            rd_data[RES_W-1:0] = data_flat[rd_slot*RES_W +: RES_W];
            rd_data[RES_W]     = ovr[rd_slot];
            rd_data[RES_W+1]   = valid[rd_slot];
        end else begin
            case (rd_addr)
                A_PEND: rd_data[N-1:0] = pending;
                A_EVOV: rd_data[N-1:0] = evov;
                A_STAT: begin
                    rd_data[LINES-1:0]       = flag;
                    rd_data[2*LINES-1:LINES] = ovw;
                    rd_data[2*LINES]         = busy;
                    rd_data[2*LINES+1]       = |valid;
                    rd_data[2*LINES+2]       = |ovr;
                    rd_data[2*LINES+3]       = |evov;
                    rd_data[2*LINES+4]       = |ovw;
                end
                A_IEN:  rd_data[LINES-1:0]    = ien_q;
                A_MODE: rd_data[N-1:0]        = mode_q;
                A_DLY:  rd_data[LINES*DW-1:0] = dly_q;
                default: begin
                    for (int k = 0; k < LINES; k++) begin
                        if (rd_addr == A_LSEL + ADDR_W'(k)) rd_data[N-1:0] = lsel_q[k];
                    end
                end
            endcase
        end
    end

    // R11
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!busy && irq == '0));
endmodule

// File: tb/tb_adc_slot_tracker.sv
`timescale 1ns/1ps
module tb_adc_slot_tracker;
    localparam int N = 19;
    localparam real HALF = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        conv_start;
    logic [4:0]  conv_slot;
    logic        conv_done = 1'b0;
    logic [15:0] conv_result = '0;
    logic        busy;
    logic [3:0]  irq;

    int total = 0;
    int bad = 0;
    bit ended = 0;
    logic [15:0] exp_data [N];

    always #(HALF) clk = ~clk;

    adc_slot_tracker dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .conv_start(conv_start),
        .conv_slot(conv_slot), .conv_done(conv_done), .conv_result(conv_result),
        .busy(busy), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic rd_clr(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Waits (from the current negedge) for a start pulse; returns its slot.
    task automatic wait_start(output int slot);
        int n = 0;
        #1;
        while (!conv_start && n < 60) begin
            @(negedge clk); #1; n++;
        end
        if (!conv_start) begin
            chk(32'd0, 32'd1, "R2 start timeout");
            slot = -1;
        end else begin
            slot = int'(conv_slot);
        end
    endtask

    // Completes the conversion that is in flight.
    task automatic finish(input int slot, input logic [15:0] v);
        @(negedge clk);
        conv_done = 1'b1; conv_result = v;
        @(negedge clk);
        conv_done = 1'b0;
        if (slot >= 0 && slot < N) exp_data[slot] = v;
    endtask

    task automatic clear_all_results();
        logic [31:0] d;
        for (int s = 0; s < N; s++) rd_clr(6'h20 + 6'(s), d);
    endtask

    initial begin
        #(2.0 * HALF * 200000);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] mask;
        int s;
        int cnt;
        for (int i = 0; i < N; i++) exp_data[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        chk({31'd0, conv_start}, 0, "R11 conv_start");
        chk({31'd0, busy}, 0, "R11 busy");
        chk({28'd0, irq}, 0, "R11 irq");
        for (int a = 1; a < 12; a++) begin
            rd(6'(a), d);
            chk(d, 0, $sformatf("R11 reg %0d", a));
        end
        for (int i = 0; i < N; i++) begin
            rd(6'h20 + 6'(i), d);
            chk(d, 0, "R11 result word");
        end

        // R1 R2 R5: priority sweep over several trigger masks
        for (int it = 0; it < 10; it++) begin
            mask = (it == 0) ? ((32'd1 << N) - 1)
                             : (((it * 32'h9E3779B1) ^ (it << 7)) & ((32'd1 << N) - 1));
            if (mask == 0) mask = 32'd1;
            wr(6'h00, mask);
            for (int e = 0; e < N; e++) begin
                if (mask[e]) begin
                    wait_start(s);
                    chk(s, e, "R2 lowest slot first");
                    if (e == $countones(mask[N-1:0]) - 1 || e == 0) ;
                    chk({31'd0, busy}, 0, "R2 idle at start");
                    @(negedge clk);
                    chk({31'd0, busy}, 1, "R2 busy after start");
                    rd_addr = 6'h01; #1;
                    chk(rd_data & ~((32'd1 << e) - 1), mask & ~((32'd1 << e) - 1), "R1 pending held");
                    finish(e, 16'((e * 37 + it * 1013) & 16'hFFFF));
                end
            end
            rd(6'h01, d);
            chk(d, 0, "R1 pending drained");
            for (int i = 0; i < N; i++) begin
                rd_clr(6'h20 + 6'(i), d);
                chk(d, (mask[i] ? 32'h20000 : 32'h0) | {16'd0, exp_data[i]}, "R5 result word");
            end
        end

        // R4 R3: retrigger while in flight, then cancel
        wr(6'h00, 32'd1 << 3);
        wait_start(s);
        chk(s, 3, "R2 slot 3 issued");
        wr(6'h00, 32'd1 << 3);
        rd(6'h02, d);
        chk(d, 32'd1 << 3, "R4 event overrun set");
        rd(6'h03, d);
        chk(d[11], 1, "R6 any event overrun");
        chk(d[8], 1, "R2 busy status");
        wr(6'h00, (32'd1 << 4) | (32'd1 << 6));
        wr(6'h01, 32'd1 << 6);
        rd(6'h01, d);
        chk(d, (32'd1 << 3) | (32'd1 << 4), "R3 cancel");
        finish(3, 16'h0333);
        wait_start(s);
        chk(s, 4, "R3 next after cancel");
        finish(4, 16'h0444);
        cnt = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); #1;
            if (conv_start) cnt++;
        end
        chk(cnt, 0, "R4 R3 no further conversions");
        rd(6'h01, d);
        chk(d, 0, "R1 pending empty");
        wr(6'h02, 32'd1 << 3);
        rd(6'h02, d);
        chk(d, 0, "R4 event overrun cleared");
        rd(6'h03, d);
        chk(d[11], 0, "R6 event summary cleared");

        // R5 R6: data overrun and summaries
        clear_all_results();
        rd(6'h03, d);
        chk(d[10:9], 0, "R6 summaries idle");
        wr(6'h00, 32'd1 << 1);
        wait_start(s);
        finish(s, 16'hAAAA);
        rd(6'h03, d);
        chk(d[10:9], 2'b01, "R6 any valid");
        wr(6'h00, 32'd1 << 1);
        wait_start(s);
        finish(s, 16'h5A5A);
        rd(6'h03, d);
        chk(d[10:9], 2'b11, "R6 any overrun");
        rd_clr(6'h21, d);
        chk(d, 32'h35A5A, "R5 overrun word");
        rd(6'h21, d);
        chk(d, 32'h05A5A, "R5 read clears flags");
        rd(6'h03, d);
        chk(d[10:9], 0, "R6 summaries cleared");

        // R8 R7: end-of-conversion flag on line 1, slot 5
        wr(6'h04, 32'hF);
        wr(6'h09, 32'd1 << 5);
        wr(6'h00, 32'd1 << 5);
        wait_start(s);
        chk({28'd0, irq}, 0, "R8 no flag before done");
        finish(s, 16'h0055);
        #1 chk({28'd0, irq}, 32'h2, "R8 end flag at done edge");
        wr(6'h03, 32'h2);
        rd(6'h03, d);
        chk(d[3:0], 0, "R7 flag cleared");

        // R9: start-of-conversion delay sweep on line 1
        wr(6'h05, 32'd1 << 5);
        for (int dl = 0; dl < 16; dl++) begin
            wr(6'h06, 32'(dl) << 4);
            wr(6'h00, 32'd1 << 5);
            wait_start(s);
            cnt = 0;
            @(negedge clk); #1;
            while (!irq[1] && cnt < 30) begin
                cnt++;
                @(negedge clk); #1;
            end
            chk(cnt, dl, $sformatf("R9 delay %0d", dl));
            finish(s, 16'(dl));
            wr(6'h03, 32'h2);
        end
        rd(6'h03, d);
        chk(d[7:0], 0, "R10 no overwrite in sweep");

        // R7: unselected slot and disabled enable
        wr(6'h05, 32'd0);
        wr(6'h0B, 32'd1 << 8);
        wr(6'h00, 32'd1 << 9);
        wait_start(s);
        finish(s, 16'h0009);
        rd(6'h03, d);
        chk(d[3], 0, "R7 unselected slot ignored");
        wr(6'h04, 32'h7);
        wr(6'h00, 32'd1 << 8);
        wait_start(s);
        finish(s, 16'h0008);
        rd(6'h03, d);
        chk(d[3], 1, "R7 flag set");
        chk(irq[3], 0, "R7 irq masked");
        wr(6'h03, 32'h8);

        // R10: overwrite on line 2, slot 7 end mode
        wr(6'h0A, 32'd1 << 7);
        for (int r = 0; r < 2; r++) begin
            wr(6'h00, 32'd1 << 7);
            wait_start(s);
            finish(s, 16'h0007);
        end
        rd(6'h03, d);
        chk({19'd0, d[12], d[7:4], d[3:0], 4'd0}, {19'd0, 1'b1, 4'b0100, 4'b0100, 4'd0}, "R10 overwrite");
        wr(6'h03, 32'h44);
        rd(6'h03, d);
        chk(d[12:0] & 13'h10FF, 0, "R10 overwrite cleared");

        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule